// File: doc/BRIEF.md
# Dual-Direction Storage Transceiver Channel

This block joins two 18-bit ports, A and B, with one path in each direction. Each path keeps one storage register and has four controls. A pass signal makes the path transparent. A strobe signal has its rising edges captured. An active-low strobe gate decides whether those edges count. An active-low output enable decides whether the destination port is driven. With these controls a path can run in one of four ways: it can follow its source, hold a value, capture on a strobe edge, or capture only on the edges that the gate allows.

The whole block runs on one system clock. The strobe inputs are sampled as ordinary signals, and a rising edge is detected by comparing the current sample with the previous one. Transparent data reaches the destination output in the same cycle. A captured word appears on the destination output in the cycle after the system clock edge that detected the strobe edge. Each path presents its data word and a separate drive flag, so a pad ring above it can build the three-state pins.

Top module: `ubt_channel`

## Requirements
- R1: While rst_n is low, both drive flags are 0 and both stored words clear to zero. The previous-strobe sample resets to 1, so a strobe held high through reset release is not counted as a rising edge.
- R2: Out of reset, a path's drive flag is 1 exactly when its active-low output enable is 0. The two drive flags are never 1 together while the environment keeps at most one output enable low.
- R3: While a path's pass signal is 1, its destination output equals its source input in the same cycle.
- R4: While the pass signal is 1, the stored word follows the source at every system clock edge. After the pass signal falls, the output keeps the source value sampled at the last edge while it was still 1.
- R5: With the pass signal 0 and no rising strobe edge, the destination output holds its previous value.
- R6: With the pass signal 0 and the strobe gate 0, a sampled 0-to-1 change of the strobe stores the source word at that system clock edge. The word appears on the output from the next cycle.
- R7: While the strobe gate is 1, strobe edges are ignored and the output keeps its value.
- R8: A falling strobe edge never stores data.
- R9: The B-to-A path behaves like the A-to-B path under its own four controls. Controls of one path have no effect on the other path's output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| a_in | input | 18 | Word received on port A |
| b_in | input | 18 | Word received on port B |
| ab_oe_n | input | 1 | Active-low output enable toward B |
| ab_le | input | 1 | Pass signal, A to B |
| ab_clk | input | 1 | Strobe, A to B |
| ab_ce_n | input | 1 | Active-low strobe gate, A to B |
| ba_oe_n | input | 1 | Active-low output enable toward A |
| ba_le | input | 1 | Pass signal, B to A |
| ba_clk | input | 1 | Strobe, B to A |
| ba_ce_n | input | 1 | Active-low strobe gate, B to A |
| b_out | output | 18 | Word presented to port B |
| b_drive | output | 1 | Drive flag for port B pads |
| a_out | output | 18 | Word presented to port A |
| a_drive | output | 1 | Drive flag for port A pads |

## Verification
A wrong stored word stays hidden while the pass signal is 1. It appears on the destination output in the first cycle with the pass signal at 0, and it stays there through every hold cycle until the next capture. A wrong previous-strobe sample shows up one cycle after the faulty edge, either as a spurious capture or as a missed one. This is why the stimulus alternates the pass signal and the strobe gate around strobe edges. Drive flag faults show at once in the same cycle, so the bench also checks the flags while reset is held.

// File: rtl/ubt_pkg.sv
package ubt_pkg;

  localparam int unsigned UBT_WIDTH = 18;
  localparam int unsigned UBT_DIRS  = 2;

  // Rising edge of a sampled strobe: now high, previous sample low.
  function automatic logic strobe_rise(input logic now_lvl, input logic prev_lvl);
    return now_lvl & ~prev_lvl;
  endfunction

  // Storage update rule; the pass signal takes precedence over the strobe.
  function automatic logic [UBT_WIDTH-1:0] store_next(
    input logic                 pass,
    input logic                 cap,
    input logic [UBT_WIDTH-1:0] src,
    input logic [UBT_WIDTH-1:0] cur
  );
    if (pass)      return src;
    else if (cap)  return src;
    else           return cur;
  endfunction

  // What the destination sees: the live source when transparent, else storage.
  function automatic logic [UBT_WIDTH-1:0] view_sel(
    input logic                 pass,
    input logic [UBT_WIDTH-1:0] src,
    input logic [UBT_WIDTH-1:0] cur
  );
    return pass ? src : cur;
  endfunction

endpackage

// File: rtl/ubt_edge_detect.sv
module ubt_edge_detect #(
  parameter logic PREV_RESET = 1'b1
) (
  input  logic clk,
  input  logic rst_n,
  input  logic strobe,
  input  logic gate_n,
  output logic cap
);
  logic prev_q;
  logic rise;

  always_ff @(posedge clk) begin
    if (!rst_n) prev_q <= PREV_RESET;
    else        prev_q <= strobe;
  end

  assign rise = ubt_pkg::strobe_rise(strobe, prev_q);
  assign cap  = rise & ~gate_n;
endmodule

// File: rtl/ubt_store_cell.sv
module ubt_store_cell #(
  parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         pass,
  input  logic         cap,
  input  logic [W-1:0] src,
  output logic [W-1:0] view
);
  logic [W-1:0] st_q;

  always_ff @(posedge clk) begin
    if (!rst_n) st_q <= '0;
    else        st_q <= ubt_pkg::store_next(pass, cap, src, st_q);
  end

  assign view = ubt_pkg::view_sel(pass, src, st_q);
endmodule

// File: rtl/ubt_drive_gate.sv
module ubt_drive_gate (
  input  logic rst_n,
  input  logic oe_n,
  output logic drive
);
  assign drive = rst_n & ~oe_n;
endmodule

// File: rtl/ubt_direction.sv
module ubt_direction #(
  parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] src,
  input  logic         oe_n,
  input  logic         pass,
  input  logic         strobe,
  input  logic         gate_n,
  output logic [W-1:0] dst,
  output logic         drive,
  output logic         cap
);
  ubt_edge_detect #(.PREV_RESET(1'b1)) u_edge (
    .clk(clk), .rst_n(rst_n), .strobe(strobe), .gate_n(gate_n), .cap(cap)
  );

  ubt_store_cell #(.W(W)) u_cell (
    .clk(clk), .rst_n(rst_n), .pass(pass), .cap(cap), .src(src), .view(dst)
  );

  ubt_drive_gate u_drv (
    .rst_n(rst_n), .oe_n(oe_n), .drive(drive)
  );
endmodule

// File: rtl/ubt_channel.sv
module ubt_channel #(
  parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  input  logic         ab_oe_n,
  input  logic         ab_le,
  input  logic         ab_clk,
  input  logic         ab_ce_n,
  input  logic         ba_oe_n,
  input  logic         ba_le,
  input  logic         ba_clk,
  input  logic         ba_ce_n,
  output logic [W-1:0] b_out,
  output logic         b_drive,
  output logic [W-1:0] a_out,
  output logic         a_drive
);
  localparam int unsigned NDIR = ubt_pkg::UBT_DIRS;

  logic [NDIR-1:0][W-1:0] d_src, d_dst;
  logic [NDIR-1:0]        d_oe_n, d_pass, d_strobe, d_gate_n, d_drive, d_cap;

  // index 0: A toward B, index 1: B toward A
  assign d_src    = {b_in,    a_in};
  assign d_oe_n   = {ba_oe_n, ab_oe_n};
  assign d_pass   = {ba_le,   ab_le};
  assign d_strobe = {ba_clk,  ab_clk};
  assign d_gate_n = {ba_ce_n, ab_ce_n};

  for (genvar g = 0; g < NDIR; g++) begin : g_dir
    ubt_direction #(.W(W)) u_dir (
      .clk(clk), .rst_n(rst_n), .src(d_src[g]), .oe_n(d_oe_n[g]),
      .pass(d_pass[g]), .strobe(d_strobe[g]), .gate_n(d_gate_n[g]),
      .dst(d_dst[g]), .drive(d_drive[g]), .cap(d_cap[g])
    );
  end

  // named capture events for the checker
  logic ab_cap, ba_cap;
  assign ab_cap = d_cap[0];
  assign ba_cap = d_cap[1];

  assign b_out   = d_dst[0];
  assign b_drive = d_drive[0];
  assign a_out   = d_dst[1];
  assign a_drive = d_drive[1];
endmodule

// File: rtl/ubt_channel_chk.sv
module ubt_channel_chk #(
  parameter int unsigned W = ubt_pkg::UBT_WIDTH
) (
  input logic         clk,
  input logic         rst_n,
  input logic [W-1:0] a_in,
  input logic [W-1:0] b_in,
  input logic         ab_le,
  input logic         ab_ce_n,
  input logic         ba_le,
  input logic [W-1:0] a_out,
  input logic [W-1:0] b_out,
  input logic         a_drive,
  input logic         b_drive,
  input logic         ab_cap,
  input logic         ba_cap
);
  p_reset_quiet_r1: assert property (@(posedge clk)
    !rst_n |-> (!a_drive && !b_drive));

  p_no_contention_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !(a_drive && b_drive));

  p_transparent_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ab_le |-> (b_out == a_in));

  p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!ab_le && !ab_cap ##1 !ab_le) |-> $stable(b_out));

  p_capture_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (ab_cap && !ab_le ##1 !ab_le) |-> (b_out == $past(a_in)));

  p_gate_blocks_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ab_ce_n |-> !ab_cap);

  p_mirror_transparent_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ba_le |-> (a_out == b_in));

  p_mirror_capture_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (ba_cap && !ba_le ##1 !ba_le) |-> (a_out == $past(b_in)));
endmodule

bind ubt_channel ubt_channel_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
  .ab_le(ab_le), .ab_ce_n(ab_ce_n), .ba_le(ba_le),
  .a_out(a_out), .b_out(b_out), .a_drive(a_drive), .b_drive(b_drive),
  .ab_cap(ab_cap), .ba_cap(ba_cap)
);

// File: tb/ubt_channel_tb.sv
module ubt_channel_tb;
  localparam int  W      = 18;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic ab_oe_n = 1'b1, ab_le = 1'b0, ab_clk = 1'b0, ab_ce_n = 1'b1;
  logic ba_oe_n = 1'b1, ba_le = 1'b0, ba_clk = 1'b0, ba_ce_n = 1'b1;
  logic [W-1:0] b_out, a_out;
  logic b_drive, a_drive;

  int checks = 0;
  int errors = 0;

  // bench reference: [0] A->B, [1] B->A
  logic [W-1:0] m_st [2];
  logic         m_prev [2];
  string        m_why [2];

  always #(CLK_PERIOD/2) clk = ~clk;

  ubt_channel #(.W(W)) u_dut (
    .clk(clk), .rst_n(rst_n), .a_in(a_in), .b_in(b_in),
    .ab_oe_n(ab_oe_n), .ab_le(ab_le), .ab_clk(ab_clk), .ab_ce_n(ab_ce_n),
    .ba_oe_n(ba_oe_n), .ba_le(ba_le), .ba_clk(ba_clk), .ba_ce_n(ba_ce_n),
    .b_out(b_out), .b_drive(b_drive), .a_out(a_out), .a_drive(a_drive)
  );

  task automatic check(input string req, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic logic [W-1:0] exp_out(input logic le, input logic [W-1:0] src, input logic [W-1:0] st);
    if (le) return src;
    return st;
  endfunction

  // model update at a system clock edge for one path
  task automatic model_edge(input int d, input logic le, input logic stb,
                            input logic ce_n, input logic [W-1:0] src);
    if (le) begin
      m_st[d] = src; m_why[d] = "R4";
    end else if (stb && !m_prev[d] && !ce_n) begin
      m_st[d] = src; m_why[d] = "R6";
    end else if (stb && !m_prev[d]) m_why[d] = "R7";
    else if (!stb && m_prev[d])     m_why[d] = "R8";
    else                            m_why[d] = "R5";
    m_prev[d] = stb;
  endtask

  task automatic check_ports();
    check(ab_le ? "R3" : m_why[0], b_out, exp_out(ab_le, a_in, m_st[0]));
    check(ba_le ? "R9 R3" : {"R9 ", m_why[1]}, a_out, exp_out(ba_le, b_in, m_st[1]));
    check("R2 b_drive", W'(b_drive), W'(!ab_oe_n));
    check("R2 a_drive", W'(a_drive), W'(!ba_oe_n));
  endtask

  // drive at negedge, check, then let the posedge update both sides
  task automatic step();
    #1;
    check_ports();
    @(posedge clk);
    model_edge(0, ab_le, ab_clk, ab_ce_n, a_in);
    model_edge(1, ba_le, ba_clk, ba_ce_n, b_in);
    @(negedge clk);
  endtask

  initial begin
    #(CLK_PERIOD * 200000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'd1357));
    for (int d = 0; d < 2; d++) begin
      m_st[d] = '0; m_prev[d] = 1'b1; m_why[d] = "R1";
    end
    // R1: drive flags low in reset even with enables asserted
    @(negedge clk);
    ab_oe_n = 1'b0; ab_clk = 1'b1; ab_ce_n = 1'b0;
    a_in = 18'h2AAAA;
    repeat (2) @(posedge clk);
    @(negedge clk);
    #1;
    check("R1 b_drive in reset", W'(b_drive), '0);
    check("R1 a_drive in reset", W'(a_drive), '0);
    check("R1 b_out cleared", b_out, '0);
    check("R1 a_out cleared", a_out, '0);
    rst_n = 1'b1;
    // R1: strobe high through reset release gives no capture
    step();
    #1;
    check("R1 no edge after reset", b_out, '0);
    // R6: low then high strobe captures
    ab_clk = 1'b0; step();
    ab_clk = 1'b1; a_in = 18'h15555; step();
    #1; check("R6 directed capture", b_out, 18'h15555);
    // R8: falling edge with new data does not capture
    ab_clk = 1'b0; a_in = 18'h00F0F; step();
    #1; check("R8 falling edge", b_out, 18'h15555);
    // R7: gate high blocks rising edge
    ab_ce_n = 1'b1; ab_clk = 1'b1; step();
    #1; check("R7 gated edge", b_out, 18'h15555);
    // R4: pass high then falls; last value retained
    ab_le = 1'b1; a_in = 18'h3C3C3; step();
    a_in = 18'h0ABCD; step();
    ab_le = 1'b0; a_in = 18'h11111; step();
    #1; check("R4 retained after pass falls", b_out, 18'h0ABCD);
    // R9: B->A directed capture, A->B unaffected
    ab_oe_n = 1'b1; ba_oe_n = 1'b0;
    ba_ce_n = 1'b0; ba_clk = 1'b0; step();
    ba_clk = 1'b1; b_in = 18'h2468A; step();
    #1; check("R9 B->A capture", a_out, 18'h2468A);
    check("R9 A->B untouched", b_out, 18'h0ABCD);

    // constrained random mix
    for (int i = 0; i < 3000; i++) begin
      int sel;
      sel = int'($urandom_range(2, 0));
      ab_oe_n = (sel != 1);
      ba_oe_n = (sel != 2);
      ab_le   = ($urandom_range(3, 0) == 0);
      ba_le   = ($urandom_range(3, 0) == 0);
      ab_clk  = $urandom_range(1, 0) != 0;
      ba_clk  = $urandom_range(1, 0) != 0;
      ab_ce_n = ($urandom_range(2, 0) == 0);
      ba_ce_n = ($urandom_range(2, 0) == 0);
      a_in    = W'($urandom);
      b_in    = W'($urandom);
      step();
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule